// File: doc/BRIEF.md
# Inter-Processor Mailbox Block

This block lets several processor channels swap short messages and signal each other through interrupts. It has a set of mailboxes. Each one has an owning source channel, a destination channel set, an interrupt enable mask and a small bank of 32-bit message words. A sender claims a mailbox by writing its own one-hot channel bit as the owner. It then fills the message words, chooses the destinations and enables, and writes the send control with 1. Each enabled destination then sees an interrupt. The receiver reads the message, may write a reply into the same words, and writes the send control with 2. That moves the interrupt back to the owner. Writing 0 to the send control clears the pending state.

Everything is reached through a simple register port with address, write enable, write data and combinational read data. Mailbox `m` occupies a 64-byte window at byte address `m*0x40`. A status area starting at `0x800` gives each channel two words, one masked and one raw. In both words bit `m` stands for mailbox `m`. Each channel also has an interrupt line, which is the OR of its masked status word.

Top module: `ipc_mailbox`

## Requirements
- R1: After a synchronous active-low reset, every owner, destination, mask, send and message register reads zero and every interrupt line is low.
- R2: Message word n (n = 0..6) of mailbox m is at byte address m*0x40 + 0x24 + 4*n. A write there stores all 32 bits and a read returns them, independently per mailbox.
- R3: Channel k is bit k of the owner register at window offset 0x00. A nonzero write takes effect only while the owner is zero, and is otherwise ignored. A write whose channel bits are all zero releases the mailbox and clears its owner, destinations, mask, send control and all message words.
- R4: A write to window offset 0x04 ORs its channel bits into the destination set. A write to offset 0x08 removes them. Offset 0x0C reads back the set. Offsets 0x04 and 0x08 read as zero.
- R5: The mask works the same way: offset 0x14 ORs bits in, offset 0x18 removes them, and offset 0x1C reads the mask back.
- R6: The send control is the low two bits at offset 0x20. Value 1 sets mailbox m's raw bit for every destination channel. It sets the masked bit only for those destinations that are also in the mask.
- R7: Send value 2 sets mailbox m's raw bit only for the owner channel, and sets the masked bit if the owner is in the mask. Value 3 raises nothing.
- R8: Writing 0 to the send control clears every raw and masked bit of that mailbox. The send control reads back the last value written.
- R9: For channel c, the masked status word is at 0x800 + 8*c and the raw status word is at 0x804 + 8*c. Bit m of each word is mailbox m, and several mailboxes can be set at once.
- R10: irq_o[c] is high exactly when channel c's masked status word is nonzero.
- R11: The following all read zero, and writes to them change no state: the mode offset 0x10, mailbox windows at or above the mailbox count, status addresses for channels at or above the channel count, and any other unused address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 4 | One interrupt line per channel |

## Verification
The send control is driven with each of its values on a mailbox whose destination set and mask overlap only partly. Comparing raw and masked words on every channel separates destination-steered raising from owner-steered raising, and separates both from the effect of the mask. A second mailbox is kept pending on another channel. This shows that status bits and interrupt lines combine across mailboxes, and that releasing one mailbox leaves the other untouched. Owner writes are applied both while the owner is zero and while it is nonzero. Writes to the mode offset and to out-of-range windows are checked by reading those addresses and the neighbouring state afterwards.

// File: rtl/ipc_mbox_pkg.sv
// Shared encodings for the mailbox block: register word indices inside a
// mailbox window and the send-control values. Assumes 64-byte windows
// (16 words) with the message words filling the top of the window.
package ipc_mbox_pkg;

    localparam logic [3:0] REG_OWNER  = 4'd0;
    localparam logic [3:0] REG_DSET   = 4'd1;
    localparam logic [3:0] REG_DCLR   = 4'd2;
    localparam logic [3:0] REG_DSTAT  = 4'd3;
    localparam logic [3:0] REG_MODE   = 4'd4;
    localparam logic [3:0] REG_MSET   = 4'd5;
    localparam logic [3:0] REG_MCLR   = 4'd6;
    localparam logic [3:0] REG_MSTAT  = 4'd7;
    localparam logic [3:0] REG_SEND   = 4'd8;
    localparam int         MSG_BASE   = 9;
    localparam int         WIN_WORDS  = 16;
    localparam int         MSG_WORDS  = WIN_WORDS - MSG_BASE;
    localparam int         WIN_SHIFT  = 6;

    typedef enum logic [1:0] {
        SEND_IDLE = 2'd0,
        SEND_FWD  = 2'd1,
        SEND_ACK  = 2'd2,
        SEND_NONE = 2'd3
    } send_e;

endpackage

// File: rtl/ipc_mbox_slot.sv
// One mailbox: owner, destination set, mask, send control and message words.
// Produces the per-channel raw interrupt vector and the mask for the
// status combiner. Assumes at most one write per cycle, selected by we_i.
module ipc_mbox_slot
    import ipc_mbox_pkg::*;
#(
    parameter int NUM_CHAN = 4,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [3:0]          idx_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [NUM_CHAN-1:0] raw_o,
    output logic [NUM_CHAN-1:0] mask_o
);
    localparam int PAD_W = DATA_W - NUM_CHAN;

    logic [NUM_CHAN-1:0] owner_q;
    logic [NUM_CHAN-1:0] dest_q;
    logic [NUM_CHAN-1:0] mask_q;
    send_e               send_q;
    logic [DATA_W-1:0]   msg_q [MSG_WORDS];
    logic [NUM_CHAN-1:0] wbits;
    logic                release_w;

    assign wbits     = wdata_i[NUM_CHAN-1:0];
    assign release_w = we_i && (idx_i == REG_OWNER) && (wbits == '0);

    // Control registers: claim/release, set/clear groups and send control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
            dest_q  <= '0;
            mask_q  <= '0;
            send_q  <= SEND_IDLE;
        end else if (release_w) begin
            owner_q <= '0;
            dest_q  <= '0;
            mask_q  <= '0;
            send_q  <= SEND_IDLE;
        end else if (we_i) begin
            case (idx_i)
                REG_OWNER: if (owner_q == '0) owner_q <= wbits;
                REG_DSET:  dest_q <= dest_q | wbits;
                REG_DCLR:  dest_q <= dest_q & ~wbits;
                REG_MSET:  mask_q <= mask_q | wbits;
                REG_MCLR:  mask_q <= mask_q & ~wbits;
                REG_SEND:  send_q <= send_e'(wdata_i[1:0]);
                default:   ;
            endcase
        end
    end

    // Message words, one register each; cleared on release.
    for (genvar w = 0; w < MSG_WORDS; w++) begin : g_msg
        always_ff @(posedge clk) begin
            if (!rst_n || release_w) begin
                msg_q[w] <= '0;
            end else if (we_i && idx_i == 4'(MSG_BASE + w)) begin
                msg_q[w] <= wdata_i;
            end
        end
    end

    // Interrupt steering: destinations on forward, owner on acknowledge.
    always_comb begin
        case (send_q)
            SEND_FWD: raw_o = dest_q;
            SEND_ACK: raw_o = owner_q;
            default:  raw_o = '0;
        endcase
    end

    assign mask_o = mask_q;

    // Read-back multiplexer for this window.
    always_comb begin
        rdata_o = '0;
        case (idx_i)
            REG_OWNER: rdata_o = {{PAD_W{1'b0}}, owner_q};
            REG_DSTAT: rdata_o = {{PAD_W{1'b0}}, dest_q};
            REG_MSTAT: rdata_o = {{PAD_W{1'b0}}, mask_q};
            REG_SEND:  rdata_o = {{(DATA_W-2){1'b0}}, send_q};
            default: begin
                for (int w = 0; w < MSG_WORDS; w++) begin
                    if (idx_i == 4'(MSG_BASE + w)) rdata_o = msg_q[w];
                end
            end
        endcase
    end

    // R3
    owner_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && idx_i == REG_OWNER && owner_q != '0 && wbits != '0)
        |=> owner_q == $past(owner_q));

    // R3
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_w |=> (owner_q == '0 && dest_q == '0 && mask_q == '0 && raw_o == '0));

    // R4
    dest_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && idx_i == REG_DSET) |=> dest_q == ($past(dest_q) | $past(wbits)));

    // R5
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && idx_i == REG_MCLR) |=> mask_q == ($past(mask_q) & ~$past(wbits)));

    // R8
    send_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && idx_i == REG_SEND && wdata_i[1:0] == 2'd0) |=> raw_o == '0);

endmodule

// File: rtl/ipc_mbox_irq.sv
// Status combiner: turns per-mailbox channel vectors into per-channel
// status words (bit m = mailbox m) and drives one interrupt per channel.
// Purely combinational; assumes inputs come from registers.
module ipc_mbox_irq #(
    parameter int NUM_MBOX = 8,
    parameter int NUM_CHAN = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_MBOX-1:0][NUM_CHAN-1:0]  raw_mc_i,
    input  logic [NUM_MBOX-1:0][NUM_CHAN-1:0]  mask_mc_i,
    output logic [NUM_CHAN-1:0][NUM_MBOX-1:0]  raw_cm_o,
    output logic [NUM_CHAN-1:0][NUM_MBOX-1:0]  masked_cm_o,
    output logic [NUM_CHAN-1:0]                irq_o
);
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mbox
            // Transpose one mailbox/channel bit and apply the mask.
            assign raw_cm_o[c][m]    = raw_mc_i[m][c];
            assign masked_cm_o[c][m] = raw_mc_i[m][c] & mask_mc_i[m][c];
        end
        // One interrupt line per channel from its masked word.
        assign irq_o[c] = |masked_cm_o[c];

        // R10
        irq_has_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] |-> (raw_cm_o[c] != '0));
    end

endmodule

// File: rtl/ipc_mailbox.sv
// Top of the mailbox block: decodes the register port into mailbox windows
// and the per-channel status area, and collects the read data.
// Assumes NUM_MBOX * 64 bytes fit below the status area at the top half.
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int NUM_MBOX = 8,
    parameter int NUM_CHAN = 4,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_CHAN-1:0] irq_o
);
    localparam int MB_IDX_W = ADDR_W - 1 - WIN_SHIFT;
    localparam int CH_IDX_W = ADDR_W - 1 - 3;
    localparam int ST_PAD_W = DATA_W - NUM_MBOX;

    logic                               stat_area;
    logic [MB_IDX_W-1:0]                mb_idx;
    logic [CH_IDX_W-1:0]                ch_idx;
    logic [3:0]                         reg_idx;
    logic [NUM_MBOX-1:0]                mb_hit;
    logic [DATA_W-1:0]                  slot_rdata [NUM_MBOX];
    logic [NUM_MBOX-1:0][NUM_CHAN-1:0]  raw_mc;
    logic [NUM_MBOX-1:0][NUM_CHAN-1:0]  mask_mc;
    logic [NUM_CHAN-1:0][NUM_MBOX-1:0]  raw_cm;
    logic [NUM_CHAN-1:0][NUM_MBOX-1:0]  masked_cm;

    assign stat_area = bus_addr[ADDR_W-1];
    assign mb_idx    = bus_addr[ADDR_W-2:WIN_SHIFT];
    assign ch_idx    = bus_addr[ADDR_W-2:3];
    assign reg_idx   = bus_addr[WIN_SHIFT-1:2];

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_slot
        // Window select for mailbox m.
        assign mb_hit[m] = !stat_area && (32'(mb_idx) == m);

        ipc_mbox_slot #(
            .NUM_CHAN (NUM_CHAN),
            .DATA_W   (DATA_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (bus_we && mb_hit[m]),
            .idx_i   (reg_idx),
            .wdata_i (bus_wdata),
            .rdata_o (slot_rdata[m]),
            .raw_o   (raw_mc[m]),
            .mask_o  (mask_mc[m])
        );
    end

    ipc_mbox_irq #(
        .NUM_MBOX (NUM_MBOX),
        .NUM_CHAN (NUM_CHAN)
    ) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw_mc_i    (raw_mc),
        .mask_mc_i   (mask_mc),
        .raw_cm_o    (raw_cm),
        .masked_cm_o (masked_cm),
        .irq_o       (irq_o)
    );

    // Read data: selected mailbox window or channel status word, else zero.
    always_comb begin
        bus_rdata = '0;
        for (int m = 0; m < NUM_MBOX; m++) begin
            if (mb_hit[m]) bus_rdata = slot_rdata[m];
        end
        for (int c = 0; c < NUM_CHAN; c++) begin
            if (stat_area && 32'(ch_idx) == c) begin
                bus_rdata = bus_addr[2] ? {{ST_PAD_W{1'b0}}, raw_cm[c]}
                                        : {{ST_PAD_W{1'b0}}, masked_cm[c]};
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> irq_o == '0);

    // R11
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_area && 32'(ch_idx) >= NUM_CHAN) |-> bus_rdata == '0);

endmodule

// File: tb/ipc_mailbox_tb.sv
// Scoreboard bench: driver tasks queue expected values, a monitor compares.
module ipc_mailbox_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_o;

    logic [31:0] exp_q [$];
    bit          kind_q [$];
    string       tag_q [$];
    bit          rd_pend = 1'b0;
    int          vectors = 0;
    int          errs = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    ipc_mailbox u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic expect_item(input bit is_irq, input logic [11:0] a,
                               input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        exp_q.push_back(e); kind_q.push_back(is_irq); tag_q.push_back(tag);
        rd_pend = 1'b1;
        @(negedge clk); #1;
        rd_pend = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        expect_item(1'b0, a, e, tag);
    endtask

    task automatic irq_chk(input logic [3:0] e, input string tag);
        expect_item(1'b1, 12'h000, {28'b0, e}, tag);
    endtask

    // Monitor: pop one expected item and compare it with the outputs.
    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            logic [31:0] e, act;
            bit k;
            string t;
            e = exp_q.pop_front(); k = kind_q.pop_front(); t = tag_q.pop_front();
            act = k ? {28'b0, irq_o} : bus_rdata;
            vectors++;
            if (act !== e) begin
                errs++;
                $display("FAIL %s: got %h expected %h", t, act, e);
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(12'h040, 32'h0, "R1 owner mb1");
        rd(12'h04C, 32'h0, "R1 dest mb1");
        rd(12'h060, 32'h0, "R1 send mb1");
        rd(12'h804, 32'h0, "R1 raw ch0");
        irq_chk(4'b0000, "R1 irq");

        // R2 message words
        for (int n = 0; n < 7; n++) wr(12'(12'h064 + 4 * n), 32'hA5000000 + n);
        wr(12'h1FC, 32'hDEADBEEF);
        for (int n = 0; n < 7; n++) rd(12'(12'h064 + 4 * n), 32'hA5000000 + n, "R2 mb1 word");
        rd(12'h1FC, 32'hDEADBEEF, "R2 mb7 word6");
        rd(12'h0BC, 32'h0, "R2 mb2 word6 untouched");

        // R3 owner claim and lock
        wr(12'h040, 32'h2);
        rd(12'h040, 32'h2, "R3 claim");
        wr(12'h040, 32'h4);
        rd(12'h040, 32'h2, "R3 locked");

        // R4 destinations
        wr(12'h044, 32'h1);
        wr(12'h044, 32'h8);
        rd(12'h04C, 32'h9, "R4 dest set");
        wr(12'h048, 32'h8);
        rd(12'h04C, 32'h1, "R4 dest clear");
        rd(12'h044, 32'h0, "R4 set offset reads zero");
        wr(12'h044, 32'h8);

        // R5 mask
        wr(12'h054, 32'h3);
        wr(12'h058, 32'h1);
        rd(12'h05C, 32'h2, "R5 mask clear");
        wr(12'h054, 32'h1);
        rd(12'h05C, 32'h3, "R5 mask set");

        // R6 forward: dest={0,3}, mask={0,1}
        wr(12'h060, 32'h1);
        rd(12'h060, 32'h1, "R8 send readback");
        rd(12'h804, 32'h2, "R6 raw ch0");
        rd(12'h81C, 32'h2, "R6 raw ch3");
        rd(12'h800, 32'h2, "R6 masked ch0");
        rd(12'h818, 32'h0, "R6 masked ch3");
        irq_chk(4'b0001, "R10 irq forward");

        // R7 acknowledge to owner ch1
        wr(12'h060, 32'h2);
        rd(12'h80C, 32'h2, "R7 raw ch1");
        rd(12'h808, 32'h2, "R7 masked ch1");
        rd(12'h804, 32'h0, "R7 raw ch0 cleared");
        irq_chk(4'b0010, "R10 irq ack");
        wr(12'h060, 32'h3);
        irq_chk(4'b0000, "R7 value 3 raises nothing");

        // R8 clear
        wr(12'h060, 32'h2);
        wr(12'h060, 32'h0);
        rd(12'h80C, 32'h0, "R8 raw ch1 cleared");
        irq_chk(4'b0000, "R8 irq low");

        // R9 two mailboxes pending
        wr(12'h140, 32'h1);
        wr(12'h144, 32'h4);
        wr(12'h154, 32'h4);
        wr(12'h160, 32'h1);
        wr(12'h060, 32'h1);
        rd(12'h810, 32'h20, "R9 masked ch2 mb5");
        rd(12'h800, 32'h2, "R9 masked ch0 mb1");
        irq_chk(4'b0101, "R10 two lines");

        // R3 release
        wr(12'h040, 32'h0);
        rd(12'h040, 32'h0, "R3 release owner");
        rd(12'h04C, 32'h0, "R3 release dest");
        rd(12'h05C, 32'h0, "R3 release mask");
        rd(12'h060, 32'h0, "R3 release send");
        rd(12'h064, 32'h0, "R3 release word0");
        irq_chk(4'b0100, "R3 other mailbox kept");
        wr(12'h040, 32'h8);
        rd(12'h040, 32'h8, "R3 reclaim");

        // R11 unmapped
        wr(12'h050, 32'h3);
        rd(12'h050, 32'h0, "R11 mode reads zero");
        wr(12'h200, 32'h1);
        rd(12'h200, 32'h0, "R11 mb8 window");
        rd(12'h1C0, 32'h0, "R11 mb7 owner untouched");
        rd(12'h820, 32'h0, "R11 ch4 status");
        rd(12'h7FC, 32'h0, "R11 high window");
        irq_chk(4'b0100, "R11 irq unchanged");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule